// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit is the last step of a single-precision arithmetic pipeline. It takes a result that is still in an intermediate form: a sign, a signed unbiased exponent and a 27-bit mantissa. The mantissa carries the hidden bit in bit 26, the 23 fraction bits in bits 25..3 and three extra guard bits in bits 2..0. The unit rounds this value in one of four modes. It denormalises tiny values with a sticky right shift, or flushes them when flushing is enabled. It saturates on overflow and packs the 32-bit IEEE 754 word. Along with the word it reports inexact, underflow and overflow flags.

Operands enter on a valid/ready stream and results leave on another. The datapath is combinational and feeds one output register. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and its flags hold steady and no new operand is taken. The rounding mode, flush enable and underflow-trap enable are sampled together with each operand. Exact-zero mantissas, NaN and infinity operands are not handled here.

Top module: `sp_round_pack`

## Requirements
- R1: The rounding mode is encoded as 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward -infinity. Rounding acts only when mantissa bits 2..0 are nonzero, and that also raises inexact. Toward zero truncates. An operand with zero guard bits and an in-range exponent gives no inexact flag.
- R2: Nearest-even adds 3 to the 27-bit mantissa when bit 3 is clear and 4 when it is set. A halfway value therefore rounds to an even fraction.
- R3: Toward +infinity adds 8 (one unit in the last place) only for a positive sign. Toward -infinity adds 8 only for a negative sign.
- R4: When rounding carries out of bit 26, the mantissa shifts right by one and the exponent rises by one.
- R5: When the final exponent exceeds 127, overflow and inexact are set. The result is a signed infinity when the mode rounds away from zero for that sign (nearest; +inf mode with a positive sign; -inf mode with a negative sign). Otherwise it is the signed largest finite value, with exponent field 0xFE and all fraction bits set.
- R6: With flushing enabled and an exponent below -126, underflow and inexact are set. The result is the smallest normal of that sign (exponent field 1) under +inf mode with a positive sign or -inf mode with a negative sign. In every other case it is a zero of that sign.
- R7: An exponent of exactly -127 whose rounding would carry out of bit 26 is not tiny. The result is the rounded value at exponent -126, with inexact set and underflow clear.
- R8: Any other exponent below -126 is shifted right by (-126 - exponent) places, with every lost bit ORed into bit 0. It then rounds at exponent -126. A result with a clear hidden bit packs with exponent field 0 and the raw fraction. Underflow is set when the guard bits are nonzero.
- R9: An exact result with exponent field 0 raises underflow only when the underflow-trap enable is set.
- R10: A normal result packs the exponent field as exponent + 127 and drops the hidden bit.
- R11: A result appears on the output one cycle after acceptance. It holds unchanged while `out_valid` is high and `out_ready` is low. After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W (10) | Signed unbiased exponent |
| in_mant | input | 27 | Hidden bit, fraction and three guard bits |
| in_rmode | input | 2 | Rounding mode (R1 encoding) |
| in_flush | input | 1 | Flush tiny results instead of denormalising |
| in_uf_trap | input | 1 | Underflow trap enable, which governs exact-tiny underflow |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
Every result, including its three flags, is due on the output in the cycle after its operand is accepted. If `out_ready` is low, it stays there until the first cycle in which `out_ready` is high. A driver pushes each hand-worked expected word and flag set into an in-order queue as it presents the operand. A monitor samples on the falling clock edge and pops one entry only in cycles where `out_valid` and `out_ready` are both high, so stalls never shift the comparison. A separate step checks the one-cycle latency directly. The monitor also checks that a stalled result is unchanged at the next falling edge.

// File: rtl/sp_rp_pkg.sv
package sp_rp_pkg;
  localparam int FRAC_W  = 23;
  localparam int GRS_W   = 3;
  localparam int MANT_W  = FRAC_W + 1 + GRS_W;
  localparam int EFLD_W  = 8;
  localparam int WORD_W  = 1 + EFLD_W + FRAC_W;
  localparam int BIAS    = (1 << (EFLD_W - 1)) - 1;
  localparam int EMIN    = 1 - BIAS;
  localparam int EMAX    = BIAS;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              inexact;
    logic              underflow;
    logic              overflow;
  } result_t;
endpackage

// File: rtl/sp_rp_rounder.sv
module sp_rp_rounder
  import sp_rp_pkg::*;
(
  input  logic              sign,
  input  logic [1:0]        rmode,
  input  logic [MANT_W-1:0] mant,
  output logic [MANT_W:0]   rounded
);
  localparam int UW = MANT_W + 1;
  localparam logic [UW-1:0] ULP = UW'(1) << GRS_W;

  logic [UW-1:0] inc;

  always_comb begin
    inc = '0;
    if (|mant[GRS_W-1:0]) begin
      unique case (rmode_e'(rmode))
        RM_NEAREST: inc = UW'(3) + UW'(mant[GRS_W]);
        RM_UP:      inc = sign ? '0 : ULP;
        RM_DOWN:    inc = sign ? ULP : '0;
        default:    inc = '0;
      endcase
    end
    rounded = {1'b0, mant} + inc;
  end

  // R2/R3: rounding never moves the magnitude down
  always_comb assert_round_monotone_R3: assert (rounded >= {1'b0, mant});
endmodule

// File: rtl/sp_rp_denorm.sv
module sp_rp_denorm
  import sp_rp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    sign,
  input  logic [1:0]              rmode,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  output logic signed [EXP_W:0]   exp_o,
  output logic [MANT_W-1:0]       mant_o,
  output logic                    inexact_o
);
  localparam int SH_W = $clog2(MANT_W) + 1;
  localparam logic [MANT_W:0] GRS_CLR = ~((MANT_W+1)'(1 << GRS_W) - (MANT_W+1)'(1));

  logic [MANT_W:0]   rnd;
  logic [MANT_W-1:0] lost_mask;
  logic [SH_W-1:0]   sh;
  logic              below, big;
  int                es;

  sp_rp_rounder u_edge_round (.sign(sign), .rmode(rmode), .mant(mant_i), .rounded(rnd));

  always_comb begin
    es        = EMIN - int'(exp_i);
    below     = int'(exp_i) < EMIN;
    big       = es >= MANT_W;
    sh        = big ? '0 : SH_W'(es);
    lost_mask = ~({MANT_W{1'b1}} << sh);
    exp_o     = {exp_i[EXP_W-1], exp_i};
    mant_o    = mant_i;
    inexact_o = 1'b0;
    if (below) begin
      exp_o = (EXP_W+1)'(EMIN);
      if (int'(exp_i) == EMIN - 1 && rnd[MANT_W]) begin
        // rounds back to the smallest normal: not tiny
        inexact_o = 1'b1;
        mant_o    = MANT_W'((rnd >> 1) & GRS_CLR);
      end else if (big) begin
        mant_o = {{(MANT_W-1){1'b0}}, |mant_i};
      end else begin
        mant_o = (mant_i >> sh) | {{(MANT_W-1){1'b0}}, |(mant_i & lost_mask)};
      end
    end
  end
endmodule

// File: rtl/sp_rp_pack.sv
module sp_rp_pack
  import sp_rp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                  sign,
  input  logic [1:0]            rmode,
  input  logic signed [EXP_W:0] exp_i,
  input  logic [MANT_W-1:0]     mant_i,
  input  logic                  early_inexact,
  input  logic                  uf_trap,
  output result_t               res
);
  localparam int SIG_W = FRAC_W + 1;

  logic [MANT_W:0]  rnd, m;
  logic [SIG_W-1:0] sig;
  logic             to_inf;
  int               e;

  sp_rp_rounder u_main_round (.sign(sign), .rmode(rmode), .mant(mant_i), .rounded(rnd));

  always_comb begin
    res.inexact   = early_inexact;
    res.underflow = 1'b0;
    res.overflow  = 1'b0;
    m = {1'b0, mant_i};
    e = int'(exp_i);
    if (|mant_i[GRS_W-1:0]) begin
      res.inexact = 1'b1;
      if (!mant_i[MANT_W-1]) res.underflow = 1'b1;
      m = rnd;
      if (m[MANT_W]) begin
        m = m >> 1;
        e = e + 1;
      end
    end
    sig    = SIG_W'(m >> GRS_W);
    to_inf = (rmode_e'(rmode) == RM_NEAREST) ||
             (rmode_e'(rmode) == RM_UP && !sign) ||
             (rmode_e'(rmode) == RM_DOWN && sign);
    if (e > EMAX) begin
      res.overflow = 1'b1;
      res.inexact  = 1'b1;
      res.word     = to_inf ? {sign, {EFLD_W{1'b1}}, {FRAC_W{1'b0}}}
                            : {sign, {(EFLD_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else if (!sig[SIG_W-1]) begin
      res.underflow = res.underflow | uf_trap;
      res.word      = {sign, {EFLD_W{1'b0}}, sig[FRAC_W-1:0]};
    end else begin
      res.word = {sign, EFLD_W'(e + BIAS), sig[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
  import sp_rp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic [1:0]              in_rmode,
  input  logic                    in_flush,
  input  logic                    in_uf_trap,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_word,
  output logic                    out_inexact,
  output logic                    out_underflow,
  output logic                    out_overflow
);
  logic signed [EXP_W:0] dn_exp;
  logic [MANT_W-1:0]     dn_mant;
  logic                  dn_inexact, flush_hit, to_min, fire;
  result_t               pk_res, flush_res, nxt_res, res_q;

  sp_rp_denorm #(.EXP_W(EXP_W)) u_denorm (
    .sign(in_sign), .rmode(in_rmode), .exp_i(in_exp), .mant_i(in_mant),
    .exp_o(dn_exp), .mant_o(dn_mant), .inexact_o(dn_inexact)
  );

  sp_rp_pack #(.EXP_W(EXP_W)) u_pack (
    .sign(in_sign), .rmode(in_rmode), .exp_i(dn_exp), .mant_i(dn_mant),
    .early_inexact(dn_inexact), .uf_trap(in_uf_trap), .res(pk_res)
  );

  always_comb begin
    flush_hit = in_flush && (int'(in_exp) < EMIN);
    to_min    = (rmode_e'(in_rmode) == RM_UP && !in_sign) ||
                (rmode_e'(in_rmode) == RM_DOWN && in_sign);
    flush_res.inexact   = 1'b1;
    flush_res.underflow = 1'b1;
    flush_res.overflow  = 1'b0;
    flush_res.word      = {in_sign, (WORD_W-1)'(0)};
    if (to_min) flush_res.word[FRAC_W] = 1'b1;
    nxt_res = flush_hit ? flush_res : pk_res;
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        res_q     <= nxt_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_word      = res_q.word;
  assign out_inexact   = res_q.inexact;
  assign out_underflow = res_q.underflow;
  assign out_overflow  = res_q.overflow;

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_inexact));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mant[GRS_W-1:0] == '0 && int'(in_exp) >= EMIN &&
    int'(in_exp) < EMAX |=> !out_inexact);

  assert_flush_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_flush && int'(in_exp) < EMIN |=> out_inexact && out_underflow);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_inexact && out_word[WORD_W-2 -: EFLD_W] >= 8'hFE);

  assert_allones_exp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[WORD_W-2 -: EFLD_W] == 8'hFF |-> out_overflow);
endmodule

// File: tb/sp_round_pack_bench.sv
module sp_round_pack_bench;
  import sp_rp_pkg::*;

  localparam int EXP_W = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic in_sign = 1'b0;
  logic signed [EXP_W-1:0] in_exp = '0;
  logic [MANT_W-1:0] in_mant = '0;
  logic [1:0] in_rmode = '0;
  logic in_flush = 1'b0, in_uf_trap = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [31:0] out_word;
  logic out_inexact, out_underflow, out_overflow;

  int checks = 0, errors = 0;
  bit stall_en = 1'b0, done = 1'b0;
  logic [34:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sp_round_pack #(.EXP_W(EXP_W)) u_sp_round_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_rmode(in_rmode),
    .in_flush(in_flush), .in_uf_trap(in_uf_trap), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_inexact(out_inexact),
    .out_underflow(out_underflow), .out_overflow(out_overflow)
  );

  task automatic check(bit ok, string tag, logic [34:0] act, logic [34:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // word, then inexact, underflow, overflow
  task automatic send(bit s, int e, logic [26:0] m, int rm, bit fl, bit tr,
                      logic [31:0] w, bit xi, bit xu, bit xo, string tag);
    @(negedge clk);
    in_sign = s; in_exp = EXP_W'(e); in_mant = m; in_rmode = 2'(rm);
    in_flush = fl; in_uf_trap = tr; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back({w, xi, xu, xo});
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // consumer back-pressure, changed away from the sampling edge
  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      #2;
      c++;
      out_ready = stall_en ? (c % 3 == 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [34:0] prev_out = '0;
  always @(negedge clk) begin
    logic [34:0] act;
    act = {out_word, out_inexact, out_underflow, out_overflow};
    if (rst_n) begin
      if (prev_stall) check(out_valid && act == prev_out, "R11 hold under stall", act, prev_out);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected result", act, '0);
        else begin
          logic [34:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(act == e, t, act, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = act;
    end
  end

  initial begin
    #(WATCHDOG * 10);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    localparam logic [26:0] ONE = 27'h4000000;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R11 reset state", {33'b0, out_valid, in_ready}, 35'b1);
    rst_n = 1'b1;

    // R11 latency: result visible one cycle after acceptance
    @(negedge clk);
    in_sign = 0; in_exp = '0; in_mant = ONE; in_rmode = 0; in_flush = 0; in_uf_trap = 0;
    in_valid = 1'b1;
    exp_q.push_back({32'h3F800000, 3'b000}); tag_q.push_back("R10 one point zero");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid, "R11 one-cycle latency", {34'b0, out_valid}, 35'b1);

    send(0, 0, ONE | 27'd7, 1, 0, 0, 32'h3F800000, 1, 0, 0, "R1 toward zero truncates");
    send(0, 5, ONE | 27'h8, 0, 0, 0, 32'h42000001, 0, 0, 0, "R1 exact no inexact");
    send(0, 0, ONE | 27'd4, 0, 0, 0, 32'h3F800000, 1, 0, 0, "R2 tie to even down");
    send(0, 0, ONE | 27'hC, 0, 0, 0, 32'h3F800002, 1, 0, 0, "R2 tie to even up");
    send(0, 0, ONE | 27'd5, 0, 0, 0, 32'h3F800001, 1, 0, 0, "R2 above half");
    send(0, 0, ONE | 27'd3, 0, 0, 0, 32'h3F800000, 1, 0, 0, "R2 below half");
    send(0, 0, ONE | 27'd1, 2, 0, 0, 32'h3F800001, 1, 0, 0, "R3 up positive");
    send(1, 0, ONE | 27'd1, 2, 0, 0, 32'hBF800000, 1, 0, 0, "R3 up negative");
    send(1, 0, ONE | 27'd1, 3, 0, 0, 32'hBF800001, 1, 0, 0, "R3 down negative");
    send(0, 0, ONE | 27'd1, 3, 0, 0, 32'h3F800000, 1, 0, 0, "R3 down positive");
    send(0, 0, 27'h7FFFFFF, 0, 0, 0, 32'h40000000, 1, 0, 0, "R4 carry renormalises");
    send(0, 128, ONE, 0, 0, 0, 32'h7F800000, 1, 0, 1, "R5 nearest inf");
    send(0, 128, ONE, 1, 0, 0, 32'h7F7FFFFF, 1, 0, 1, "R5 zero max");
    send(1, 128, ONE, 2, 0, 0, 32'hFF7FFFFF, 1, 0, 1, "R5 up negative max");
    send(0, 128, ONE, 2, 0, 0, 32'h7F800000, 1, 0, 1, "R5 up positive inf");
    send(1, 128, ONE, 3, 0, 0, 32'hFF800000, 1, 0, 1, "R5 down negative inf");
    send(0, 128, ONE, 3, 0, 0, 32'h7F7FFFFF, 1, 0, 1, "R5 down positive max");
    send(0, 127, 27'h7FFFFFF, 0, 0, 0, 32'h7F800000, 1, 0, 1, "R5 R4 carry overflows");
    send(1, -127, ONE, 0, 1, 0, 32'h80000000, 1, 1, 0, "R6 flush nearest");
    send(0, -127, ONE, 2, 1, 0, 32'h00800000, 1, 1, 0, "R6 flush up positive");
    send(1, -127, ONE, 2, 1, 0, 32'h80000000, 1, 1, 0, "R6 flush up negative");
    send(1, -300, ONE, 3, 1, 0, 32'h80800000, 1, 1, 0, "R6 flush down negative");
    send(0, -127, ONE, 3, 1, 0, 32'h00000000, 1, 1, 0, "R6 flush down positive");
    send(0, -127, 27'h7FFFFFF, 0, 0, 0, 32'h00800000, 1, 0, 0, "R7 not tiny after round");
    send(0, -127, ONE | 27'd1, 1, 0, 0, 32'h00400000, 1, 1, 0, "R8 sticky shift by one");
    send(0, -200, ONE, 2, 0, 0, 32'h00000001, 1, 1, 0, "R8 wide sticky shift");
    send(1, -128, ONE, 0, 0, 0, 32'h80200000, 0, 0, 0, "R8 exact shift by two");
    send(0, -127, ONE, 0, 0, 0, 32'h00400000, 0, 0, 0, "R9 exact tiny no trap");
    send(0, -127, ONE, 0, 0, 1, 32'h00400000, 0, 1, 0, "R9 exact tiny trap");
    send(0, -126, ONE, 0, 0, 0, 32'h00800000, 0, 0, 0, "R10 smallest normal");
    send(0, 127, 27'h6000000, 0, 0, 0, 32'h7F400000, 0, 0, 0, "R10 largest exponent");

    // R11 back-pressure burst
    stall_en = 1'b1;
    send(0, 1, ONE, 0, 0, 0, 32'h40000000, 0, 0, 0, "R11 burst a");
    send(1, 2, ONE | 27'd1, 2, 0, 0, 32'hC0800000, 1, 0, 0, "R11 burst b");
    send(0, 3, ONE | 27'd1, 2, 0, 0, 32'h41000001, 1, 0, 0, "R11 burst c");
    send(0, 128, ONE, 1, 0, 0, 32'h7F7FFFFF, 1, 0, 1, "R11 burst d");
    send(1, -127, ONE, 0, 1, 0, 32'h80000000, 1, 1, 0, "R11 burst e");
    wait (exp_q.size() == 0);
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule